// File: doc/BRIEF.md
# Memory Bus DMA Arbiter

This block decides which of several DMA channels owns the single memory bus target, the memory access controller. Each channel has its own request line and its own grant line. The arbiter also hands the controller the encoded index of the channel that holds the grant. Once a channel is granted, the controller paces every data beat. The arbiter only has to hold the grant steady until the controller pulses `xfer_end` on the last cycle of the transfer.

Arbitration is hidden behind the running transfer. On every cycle of a transfer, the arbiter runs a round-robin search over the live requests and keeps the winner in a pending register. The search starts at the channel after the one currently granted. On the cycle after the end pulse the pending winner takes the grant, so the bus passes to the next channel without an idle cycle. If no winner is pending when the end pulse arrives, every grant drops.

The control is a three-state machine:
- IDLE: no grant is given.
- BUSY: a grant is held and no winner is pending.
- ARMED: a grant is held and a winner is pending.

The transitions are:
- IDLE to BUSY when any request is seen.
- BUSY to ARMED when a request is seen without an end pulse.
- ARMED back to BUSY when the requests vanish.
- ARMED to BUSY on an end pulse, handing over to the pending winner.
- BUSY to IDLE on an end pulse, dropping the grant.

Top module: `mbus_dma_arbiter`

## Requirements
- R1: The reset is asynchronous and active low. While it is asserted, `gnt` is all zero, `gnt_idx` is 0 and `gnt_vld` is 0. The first grant after reset searches from channel 0 upward.
- R2: `gnt` has at most one bit set. `gnt_vld` equals the OR of `gnt`. When `gnt_vld` is 1, `gnt_idx` is the position of the set bit; otherwise `gnt_idx` is 0.
- R3: When no grant is held and any request is high, the grant appears on the next cycle. It goes to the first requesting channel found by searching upward, with wrap-around, from the channel after the last granted one.
- R4: While a grant is held and `xfer_end` is low, `gnt` does not change, even if the granted channel or any other channel changes its request.
- R5: On every cycle of a transfer without an end pulse, the requests are searched as in R3 and the winner is stored as pending. If a winner is pending when `xfer_end` is high, that channel holds the grant on the next cycle, with no cycle in between without a grant.
- R6: If no winner is pending when `xfer_end` is high, all grants drop on the next cycle. This happens when no request was high on the previous cycle, or when the end pulse falls on the first cycle of a grant.
- R7: `xfer_end` has no effect while no grant is held.
- R8: The channel that currently holds the grant has the lowest priority in the search. If it is the only requester, it is granted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | One request line per DMA channel |
| xfer_end | input | 1 | Pulse from the memory controller on the last cycle of the current transfer |
| gnt | output | N | One-hot grant lines, one per channel |
| gnt_idx | output | IW | Encoded index of the granted channel (IW = clog2(N)) |
| gnt_vld | output | 1 | High while some channel holds the grant |

## Verification
The assertions assume that `req` and `xfer_end` are clean synchronous levels that change only away from the rising clock edge. They also assume the controller may raise `xfer_end` on any cycle, including cycles without a grant, where it must be ignored. The stimulus sets both inputs on the falling edge and holds them for a full cycle. It deliberately puts end pulses on the first cycle of a grant and while the bus is idle, and it drops the granted channel's request in the middle of a transfer.

// File: rtl/mbarb_pkg.sv
package mbarb_pkg;

    // Controller state: no owner, owner with no successor, owner with successor chosen
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_BUSY  = 2'd1,
        ARB_ARMED = 2'd2
    } arb_state_e;

endpackage

// File: rtl/mbarb_rr_pick.sv
// Round-robin search: first set request strictly after last_idx, wrapping.
module mbarb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last_idx,
    output logic          hit,
    output logic [IW-1:0] win_idx
);

    always_comb begin
        hit     = 1'b0;
        win_idx = last_idx;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = int'(last_idx) + k;
            if (cand >= N) begin
                cand = cand - N;
            end
            if (!hit && req[cand]) begin
                hit     = 1'b1;
                win_idx = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/mbarb_idx2oh.sv
// Index to one-hot decoder with an enable.
module mbarb_idx2oh #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);

    for (genvar g = 0; g < N; g++) begin : g_dec
        assign onehot[g] = en && (idx == IW'(g));
    end

endmodule

// File: rtl/mbarb_fsm.sv
// Grant sequencer: state register, owner register and pending register.
module mbarb_fsm
    import mbarb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_end,
    input  logic          pick_hit,
    input  logic [IW-1:0] pick_idx,
    output logic [IW-1:0] owner_idx,
    output logic          owner_vld
);

    localparam logic [IW-1:0] LAST_CH = IW'(N - 1);

    arb_state_e    state_q, state_d;
    logic [IW-1:0] own_q, own_d;
    logic [IW-1:0] pend_q, pend_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            own_q   <= LAST_CH;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            pend_q  <= pend_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        own_d   = own_q;
        pend_d  = pend_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (pick_hit) begin
                    state_d = ARB_BUSY;
                    own_d   = pick_idx;
                end
            end
            ARB_BUSY: begin
                if (xfer_end) begin
                    state_d = ARB_IDLE;
                end else if (pick_hit) begin
                    state_d = ARB_ARMED;
                    pend_d  = pick_idx;
                end
            end
            ARB_ARMED: begin
                if (xfer_end) begin
                    state_d = ARB_BUSY;
                    own_d   = pend_q;
                end else if (pick_hit) begin
                    pend_d  = pick_idx;
                end else begin
                    state_d = ARB_BUSY;
                end
            end
            default: begin
                state_d = ARB_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        owner_vld = (state_q != ARB_IDLE);
        owner_idx = owner_vld ? own_q : '0;
    end

endmodule

// File: rtl/mbus_dma_arbiter.sv
// Hidden round-robin arbiter for DMA channels sharing one memory controller.
module mbus_dma_arbiter #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          xfer_end,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_vld
);

    logic          pick_hit;
    logic [IW-1:0] pick_idx;
    logic [IW-1:0] owner_idx;
    logic          owner_vld;

    // Searches from the current (or last) owner; the same pointer serves both
    // the idle grant and the background choice made during a transfer.
    mbarb_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req      (req),
        .last_idx (owner_idx_raw),
        .hit      (pick_hit),
        .win_idx  (pick_idx)
    );

    logic [IW-1:0] owner_idx_raw;
    assign owner_idx_raw = u_fsm.own_q;

    mbarb_fsm #(.N(N), .IW(IW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_end  (xfer_end),
        .pick_hit  (pick_hit),
        .pick_idx  (pick_idx),
        .owner_idx (owner_idx),
        .owner_vld (owner_vld)
    );

    mbarb_idx2oh #(.N(N), .IW(IW)) u_dec (
        .en     (owner_vld),
        .idx    (owner_idx),
        .onehot (gnt)
    );

    assign gnt_idx = owner_idx;
    assign gnt_vld = owner_vld;

endmodule

// File: rtl/mbarb_sva.sv
// Protocol checker for the arbiter, attached by bind.
module mbarb_sva #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req,
    input logic          xfer_end,
    input logic [N-1:0]  gnt,
    input logic [IW-1:0] gnt_idx,
    input logic          gnt_vld
);

    // R2: never more than one grant, and the valid flag tracks the lines
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (gnt_vld == (gnt != '0)));

    // R2: the encoded index points at the set grant line
    a_r2_index: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> gnt[gnt_idx]);

    // R3: an idle bus with requests is granted to a requester on the next cycle
    a_r3_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld && (req != '0)) |=> (gnt_vld && ((gnt & $past(req)) != '0)));

    // R4: the grant holds until the end pulse
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !xfer_end) |=> $stable(gnt));

    // R5: a pending winner takes over with no gap
    a_r5_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && xfer_end && $past(gnt_vld) && !$past(xfer_end) && ($past(req) != '0))
        |=> gnt_vld);

    // R6: no requests on the cycle before the end pulse means the grants drop
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && xfer_end && ($past(req) == '0)) |=> !gnt_vld);

    // R7: an end pulse on an idle bus with no requests leaves it idle
    a_r7_idle_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld && xfer_end && (req == '0)) |=> !gnt_vld);

endmodule

bind mbus_dma_arbiter mbarb_sva #(.N(N), .IW(IW)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .xfer_end (xfer_end),
    .gnt      (gnt),
    .gnt_idx  (gnt_idx),
    .gnt_vld  (gnt_vld)
);

// File: tb/mbus_dma_arbiter_tb.sv
module mbus_dma_arbiter_tb;

    localparam int N  = 4;
    localparam int IW = 2;
    localparam int NV = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          xfer_end = 1'b0;
    logic [N-1:0]  gnt;
    logic [IW-1:0] gnt_idx;
    logic          gnt_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mbus_dma_arbiter #(.N(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .xfer_end (xfer_end),
        .gnt      (gnt),
        .gnt_idx  (gnt_idx),
        .gnt_vld  (gnt_vld)
    );

    // {req[3:0], xfer_end, expected gnt[3:0]} applied for one cycle, checked after it
    localparam logic [8:0] VEC [NV] = '{
        {4'b0000, 1'b0, 4'b0000},  // 0  R2 idle stays idle
        {4'b0110, 1'b0, 4'b0010},  // 1  R3 search from ch0 after reset
        {4'b0110, 1'b0, 4'b0010},  // 2  R4 hold
        {4'b0110, 1'b1, 4'b0100},  // 3  R5 handover to ch2
        {4'b0010, 1'b0, 4'b0100},  // 4  R4 owner dropped request, grant held
        {4'b1010, 1'b0, 4'b0100},  // 5  R5 pending re-chosen as ch3
        {4'b1010, 1'b1, 4'b1000},  // 6  R5 handover to ch3
        {4'b0000, 1'b0, 4'b1000},  // 7  R4 hold
        {4'b0000, 1'b1, 4'b0000},  // 8  R6 drop, nothing pending
        {4'b0000, 1'b1, 4'b0000},  // 9  R7 end pulse while idle
        {4'b1001, 1'b0, 4'b0001},  // 10 R3 wrap to ch0
        {4'b1001, 1'b1, 4'b0000},  // 11 R6 end on first grant cycle
        {4'b1001, 1'b0, 4'b1000},  // 12 R8 ch0 lowest, ch3 wins
        {4'b1001, 1'b0, 4'b1000},  // 13 R4 hold
        {4'b1001, 1'b1, 4'b0001},  // 14 R5 wrap to ch0
        {4'b1111, 1'b0, 4'b0001},  // 15 R4 hold
        {4'b1111, 1'b1, 4'b0010},  // 16 R5 next after ch0
        {4'b1111, 1'b0, 4'b0010},  // 17 R4 hold
        {4'b0000, 1'b0, 4'b0010},  // 18 R4 requests vanish
        {4'b0000, 1'b1, 4'b0000},  // 19 R6 pending cleared
        {4'b0010, 1'b0, 4'b0010},  // 20 R3 sole requester
        {4'b0010, 1'b0, 4'b0010},  // 21 R4 hold
        {4'b0010, 1'b1, 4'b0010}   // 22 R8 sole requester granted again
    };

    function automatic logic [IW-1:0] exp_index(input logic [N-1:0] oh);
        logic [IW-1:0] r;
        r = '0;
        for (int b = 0; b < N; b++) begin
            if (oh[b]) r = IW'(b);
        end
        return r;
    endfunction

    task automatic check_out(input logic [N-1:0] exp, input string tag);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s gnt actual %b expected %b", tag, gnt, exp);
        end
        checks++;
        if (gnt_vld !== (exp != '0)) begin
            errors++;
            $display("FAIL %s R2 gnt_vld actual %b expected %b", tag, gnt_vld, (exp != '0));
        end
        checks++;
        if (gnt_idx !== exp_index(exp)) begin
            errors++;
            $display("FAIL %s R2 gnt_idx actual %0d expected %0d", tag, gnt_idx, exp_index(exp));
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check_out('0, "R1 reset state");
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            req      = VEC[i][8:5];
            xfer_end = VEC[i][4];
            @(negedge clk);
            check_out(VEC[i][3:0], $sformatf("vector %0d", i));
        end
        // R1: reset asserted mid-transfer clears the grant at once
        req      = 4'b1111;
        xfer_end = 1'b0;
        rst_n    = 1'b0;
        #1;
        check_out('0, "R1 async reset");
        @(negedge clk);
        check_out('0, "R1 held in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out(4'b0001, "R1 R3 search restarts at ch0");
        @(negedge clk);
        check_out(4'b0001, "R4 hold after restart");
        xfer_end = 1'b1;
        @(negedge clk);
        check_out(4'b0010, "R5 handover after restart");
        xfer_end = 1'b0;
        req      = '0;
        @(negedge clk);
        xfer_end = 1'b1;
        @(negedge clk);
        check_out('0, "R6 drop after restart");
        xfer_end = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule